// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block divides the output of an external two-modulus prescaler by a programmable ratio. Over one output cycle it steers the prescaler with a modulus-control line. For the first A prescaler periods the line is low, which selects the larger modulus P+1. For the rest of the M periods the line is high, which selects P. The prescaler input therefore sees a total division ratio of M·P + A. Two down-counters do the work: a 10-bit main counter that counts M prescaler edges and a 7-bit swallow counter that counts A of them. Both counters reload together from the programming values at the end of every cycle.

The block is clocked by the prescaler output. A one-clock pulse on `fv` marks each completed cycle and drives the phase comparator. The programming values are sampled only when the counters reload. A flag reports a setting that cannot divide correctly.

Top module: `swallow_divider`

## Requirements
- R1: With A > 0, `modCtl` is low (prescaler set to P+1) for exactly the first A prescaler-output periods of each cycle, and it falls only when the counters reload.
- R2: After those A periods, `modCtl` stays high (prescaler set to P) until the main counter has counted M prescaler-output edges.
- R3: At the M-th edge both counters reload together from `mVal` and `aVal`, so the input-clock count between consecutive `fv` rising edges equals M·P + A.
- R4: With A = 0, `modCtl` is high for the whole cycle and the ratio is M·P.
- R5: `fv` goes high for exactly one `pscClk` period, starting at the edge that ends each cycle.
- R6: `illegal` is 1 when the loaded setting has M ≤ A or M < 8, and 0 otherwise. It changes only when the counters load.
- R7: A change to `mVal` or `aVal` in the middle of a cycle has no effect on that cycle and takes effect from the next reload.
- R8: Synchronous reset, sampled on `pscClk`, holds `fv` low, loads both counters, and sets `modCtl` to 1 exactly when `aVal` = 0. Counting starts at the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pscClk | input | 1 | Prescaler output clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mVal | input | 10 | Main count M (legal 8..1023) |
| aVal | input | 7 | Swallow count A (legal 0..127, below M) |
| modCtl | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| fv | output | 1 | Divided output, one-clock pulse per cycle |
| illegal | output | 1 | Loaded setting violates M > A or M >= 8 |

## Verification
The bench builds the block at its default widths: a 10-bit main count and a 7-bit swallow count. A behavioural prescaler runs from the 200 MHz input clock. Its modulus is a run-time variable, so small values such as P = 4 and P = 8 give short cycles for the corner cases: A = 0, A = M−1, and programming changes in the middle of a cycle. P = 64 with M = 343 and A = 48 reaches a ratio of 22000. Because the prescaler is modelled as well as the block, the ratio, the number of input clocks with `modCtl` low, and the width of the `fv` pulse can all be counted at the input-clock level.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  // Strobes issued by the control to the counter datapath each edge
  typedef struct packed {
    logic load;   // reload both counters from the programming values
    logic decM;   // step the main counter
    logic decA;   // step the swallow counter
  } swallow_strobe_t;
endpackage

// File: rtl/swallow_datapath.sv
module swallow_datapath
  import swallow_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int M_MIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  swallow_strobe_t strb,
  input  logic [M_W-1:0]  mVal,
  input  logic [A_W-1:0]  aVal,
  output logic            mTerm,
  output logic            aZero,
  output logic            aLast,
  output logic            aLoadZero,
  output logic            illegal
);
  localparam logic [M_W-1:0] M_ONE   = M_W'(1);
  localparam logic [A_W-1:0] A_ONE   = A_W'(1);
  localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);
  localparam int             CMP_W   = (M_W > A_W) ? M_W : A_W;

  logic [M_W-1:0] mCnt;
  logic [A_W-1:0] aCnt;
  logic           badSetting;

  // Setting check, widened so the comparison is lossless
  always_comb begin
    badSetting = (CMP_W'(mVal) <= CMP_W'(aVal)) || (mVal < M_FLOOR);
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      mCnt    <= mVal;
      aCnt    <= aVal;
      illegal <= badSetting;
    end else begin
      if (strb.decM) mCnt <= mCnt - M_ONE;
      if (strb.decA) aCnt <= aCnt - A_ONE;
    end
  end

  assign mTerm     = (mCnt == M_ONE);
  assign aZero     = (aCnt == '0);
  assign aLast     = (aCnt == A_ONE);
  assign aLoadZero = (aVal == '0);

  AST_RELOAD_BOTH: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (mCnt == $past(mVal)) && (aCnt == $past(aVal))); // R3

  AST_ILLEGAL_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(illegal) |-> $past(strb.load)); // R6

  AST_SWALLOW_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (aZero && !strb.load) |=> aZero); // R2
endmodule

// File: rtl/swallow_control.sv
module swallow_control
  import swallow_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            mTerm,
  input  logic            aLast,
  input  logic            aLoadZero,
  input  logic            illegal,
  output swallow_strobe_t strb,
  output logic            modCtl,
  output logic            fv
);
  logic reload;

  always_comb begin
    reload    = rst || mTerm;
    strb.load = reload;
    strb.decM = !reload;
    // swallow counter runs only while the line selects the larger modulus
    strb.decA = !reload && !modCtl;
  end

  always_ff @(posedge clk) begin
    if (reload)                 modCtl <= aLoadZero;
    else if (strb.decA && aLast) modCtl <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) fv <= 1'b0;
    else     fv <= mTerm;
  end

  AST_MC_FALLS_ONLY_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(modCtl) |-> $past(strb.load)); // R1

  AST_FV_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (fv && !illegal) |=> !fv); // R5

  AST_FV_AFTER_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    $rose(fv) |-> $past(mTerm)); // R5
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int M_MIN = 8
) (
  input  logic           pscClk,
  input  logic           rst,
  input  logic [M_W-1:0] mVal,
  input  logic [A_W-1:0] aVal,
  output logic           modCtl,
  output logic           fv,
  output logic           illegal
);
  swallow_strobe_t strb;
  logic mTerm, aZero, aLast, aLoadZero;

  swallow_datapath #(.M_W(M_W), .A_W(A_W), .M_MIN(M_MIN)) u_dp (
    .clk(pscClk), .rst(rst), .strb(strb), .mVal(mVal), .aVal(aVal),
    .mTerm(mTerm), .aZero(aZero), .aLast(aLast), .aLoadZero(aLoadZero),
    .illegal(illegal)
  );

  swallow_control u_ctl (
    .clk(pscClk), .rst(rst), .mTerm(mTerm), .aLast(aLast),
    .aLoadZero(aLoadZero), .illegal(illegal), .strb(strb),
    .modCtl(modCtl), .fv(fv)
  );

  // The control's modulus flag and the datapath's swallow count must agree
  AST_MC_TRACKS_SWALLOW: assert property (@(posedge pscClk) disable iff (rst)
    modCtl == aZero); // R2
endmodule

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;
  logic       vcoClk = 1'b0;
  logic       pscClk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] mVal = 10'd10;
  logic [6:0] aVal = 7'd5;
  logic       modCtl, fv, illegal;

  int pDiv = 8;
  int preCnt = 0;
  int total = 0;
  int bad = 0;

  // monitor state
  int vcoCount = 0, lastRise = 0, riseCnt = 0;
  int periodLen = 0, lowLen = 0, fvLen = 0, lowAcc = 0, fvAcc = 0;
  logic fvPrev = 1'b0;

  swallow_divider u_swallow_divider (
    .pscClk(pscClk), .rst(rst), .mVal(mVal), .aVal(aVal),
    .modCtl(modCtl), .fv(fv), .illegal(illegal)
  );

  always #2.5 vcoClk = ~vcoClk;

  // Two-modulus prescaler: modCtl low -> P+1, high -> P
  always @(posedge vcoClk) begin
    if (preCnt >= (modCtl ? pDiv : pDiv + 1) - 1) begin
      preCnt <= 0;
      pscClk <= 1'b1;
    end else begin
      preCnt <= preCnt + 1;
      pscClk <= 1'b0;
    end
  end

  always @(negedge vcoClk) begin
    vcoCount = vcoCount + 1;
    if (fv && !fvPrev) begin
      periodLen = vcoCount - lastRise;
      lastRise  = vcoCount;
      lowLen    = lowAcc;
      fvLen     = fvAcc;
      lowAcc    = 0;
      fvAcc     = 0;
      riseCnt   = riseCnt + 1;
    end
    lowAcc = lowAcc + (modCtl ? 0 : 1);
    fvAcc  = fvAcc + (fv ? 1 : 0);
    fvPrev = fv;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int m, input int a, input int p);
    @(negedge vcoClk);
    rst = 1'b1; mVal = 10'(m); aVal = 7'(a); pDiv = p;
    repeat (3) @(posedge pscClk);
    @(negedge vcoClk);
  endtask

  task automatic waitRises(input int n);
    int base = riseCnt;
    wait (riseCnt >= base + n);
    @(negedge vcoClk);
  endtask

  task automatic testReset();
    doReset(10, 5, 8);
    check(fv == 1'b0, "R8 fv in reset", fv, 0);
    check(modCtl == 1'b0, "R8 modCtl in reset A=5", modCtl, 0);
    check(illegal == 1'b0, "R6 legal in reset", illegal, 0);
    doReset(10, 0, 8);
    check(modCtl == 1'b1, "R8 modCtl in reset A=0", modCtl, 1);
    rst = 1'b0;
  endtask

  task automatic testRatio(input int m, input int a, input int p, input string tag);
    doReset(m, a, p);
    rst = 1'b0;
    waitRises(3);
    check(periodLen == m * p + a, {tag, " R3 ratio"}, periodLen, m * p + a);
    check(lowLen == a * (p + 1), {tag, " R1 R2 low span"}, lowLen, a * (p + 1));
    check(fvLen == ((a > 0) ? p + 1 : p), {tag, " R5 fv width"}, fvLen, (a > 0) ? p + 1 : p);
  endtask

  task automatic testZeroSwallow();
    testRatio(8, 0, 4, "A0");
    check(lowLen == 0, "R4 modCtl never low", lowLen, 0);
    check(periodLen == 32, "R4 ratio M*P", periodLen, 32);
  endtask

  task automatic testMidUpdate();
    doReset(10, 3, 8);
    rst = 1'b0;
    waitRises(2);
    repeat (20) @(negedge vcoClk);
    mVal = 10'd12; aVal = 7'd5;
    waitRises(1);
    check(periodLen == 83, "R7 old ratio kept", periodLen, 83);
    waitRises(1);
    check(periodLen == 101, "R7 new ratio", periodLen, 101);
    check(lowLen == 45, "R7 new low span", lowLen, 45);
  endtask

  task automatic testIllegal();
    doReset(8, 8, 8);
    check(illegal == 1'b1, "R6 M equal A", illegal, 1);
    doReset(7, 0, 8);
    check(illegal == 1'b1, "R6 M below 8", illegal, 1);
    doReset(9, 8, 8);
    check(illegal == 1'b0, "R6 M=9 A=8 legal", illegal, 0);
    rst = 1'b0;
    waitRises(2);
    repeat (10) @(negedge vcoClk);
    mVal = 10'd5;
    repeat (20) @(negedge vcoClk);
    check(illegal == 1'b0, "R6 R7 flag held mid-cycle", illegal, 0);
    waitRises(1);
    check(illegal == 1'b1, "R6 flag at reload", illegal, 1);
  endtask

  initial begin
    testReset();
    testRatio(10, 3, 8, "base");
    testRatio(20, 19, 8, "Amax");
    testZeroSwallow();
    testMidUpdate();
    testIllegal();
    testRatio(343, 48, 64, "wide");
    check(periodLen == 22000, "R3 ratio 22000", periodLen, 22000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge vcoClk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule